// File: doc/BRIEF.md
# Edge-Change GPIO Controller

This block is a register-mapped general-purpose I/O controller that serves up to 32 pins. The pin count is set by a parameter. Each pin is an input or an output, selected by software. An output pin drives its stored data bit. Reads of the data register always return the synchronised level seen at the pad.

Every pin has a sticky change flag. The flag is set by any transition of the synchronised pad level, in either direction. The controller never works from levels or from a single edge. Software clears a flag by writing a one to its bit. A per-pin enable decides whether a pending flag reaches the single active-high interrupt output. Clearing an enable hides the flag from the interrupt but does not discard it.

Data writes can be restricted to chosen bits through a write-mask register. A read-only type register reports that every pin detects both edges. Bus access is single-cycle: the address, write strobe and write data are sampled on the clock, and read data is combinational from the address.

Top module: `edge_gpio`

## Requirements
- R1: While reset is high and after it is released, the direction, data, enable and change registers are zero, the write mask is all ones on implemented pins, `pad_oe` and `pad_out` are zero and `irq` is low.
- R2: The direction register is at byte offset 0x00. Bit i set to 1 makes pin i an output and drives `pad_oe[i]` high; 0 makes it an input. The register reads back as written.
- R3: A write to offset 0x04 changes data bit i only where bit i of the write mask is 1. `pad_out` always equals the data register.
- R4: A read of offset 0x04 returns, in bit i, the level of `pad_in[i]` after a two-flop synchroniser. A pad change shows in the read data two clock edges after it is sampled.
- R5: Any rising or falling step of a pin's synchronised level sets that pin's change bit, which is readable at offset 0x0C. The bit is set one clock edge after the step appears at the synchroniser output.
- R6: Writing offset 0x0C clears every change bit written as 1 and leaves every bit written as 0 unchanged.
- R7: When a new transition and a write-one clear of the same bit fall in the same cycle, the change bit stays set.
- R8: `irq` is high exactly when (change AND enable) is nonzero. The enable register is at offset 0x08. Clearing an enable bit keeps the latched change bit.
- R9: Register bits at or above the pin count read as zero and ignore writes.
- R10: Offset 0x14 reads the constant 0x00000003, meaning bit 0 = rising edge and bit 1 = falling edge. Writes to it have no effect.
- R11: The write mask at offset 0x10 is readable and writable.
- R12: Offsets above 0x14, and addresses whose low two bits are not zero, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | NPIN | Pad levels, asynchronous |
| pad_out | output | NPIN | Output data to the pads |
| pad_oe | output | NPIN | Output enable per pad, 1 means output |
| irq | output | 1 | Interrupt, high while any enabled change is pending |

## Verification
A pin transition and a software clear of that same pin's change bit can arrive in the same cycle. The bench toggles a pin that already has a pending change. It then counts the synchroniser stages so that the write-one clear lands on the exact clock edge where the new transition is latched. It then reads the change register and expects the bit to still be set. A follow-up clear with no transition must leave the bit at zero, which shows that the clear itself works.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned BUS_W = 32;

    // Word index of each register (byte offset / 4)
    typedef enum logic [2:0] {
        SEL_DIR   = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_IEN   = 3'd2,
        SEL_CHG   = 3'd3,
        SEL_WMASK = 3'd4,
        SEL_TYPE  = 3'd5
    } reg_sel_e;

    localparam logic [2:0] LAST_SEL = 3'd5;

    // bit 0: rising edges detected, bit 1: falling edges detected
    localparam logic [BUS_W-1:0] TYPE_BOTH_EDGES = 32'h0000_0003;

    typedef struct packed {
        logic     hit;
        logic     wr;
        reg_sel_e sel;
    } bus_dec_t;

    function automatic bus_dec_t decode(input logic [BUS_W-1:0] word_idx,
                                        input logic [1:0]       byte_lsb,
                                        input logic             we);
        bus_dec_t d;
        d.hit = (byte_lsb == 2'b00) && (word_idx <= BUS_W'(LAST_SEL));
        d.wr  = we && d.hit;
        d.sel = d.hit ? reg_sel_e'(word_idx[2:0]) : SEL_DIR;
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] level,
    output logic [NPIN-1:0] step
);
    logic [NPIN-1:0] meta_q;
    logic [NPIN-1:0] sync_q;
    logic [NPIN-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign step  = sync_q ^ prev_q;
endmodule

// File: rtl/gpio_chg_latch.sv
module gpio_chg_latch #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] step,
    input  logic [NPIN-1:0] ack,
    input  logic [NPIN-1:0] enable,
    output logic [NPIN-1:0] pending,
    output logic            irq
);
    logic [NPIN-1:0] pend_q;

    // A new step wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~ack) | step;
    end

    assign pending = pend_q;
    assign irq     = |(pend_q & enable);
endmodule

// File: rtl/edge_gpio.sv
module edge_gpio
    import gpio_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    bus_dec_t             dec;
    logic [BUS_W-1:0]     word_idx;
    logic [NPIN-1:0]      wr_bits;
    logic [NPIN-1:0]      dir_q, dat_q, ien_q, wmask_q;
    logic [NPIN-1:0]      sync_lvl, step_vec, chg_vec, ack_vec;
    logic                 wr_dir, wr_dat, wr_ien, wr_chg, wr_msk;

    always_comb begin
        word_idx = '0;
        word_idx[IDX_W-1:0] = bus_addr[ADDR_W-1:2];
        dec = decode(word_idx, bus_addr[1:0], bus_we);
    end

    assign wr_bits = bus_wdata[NPIN-1:0];
    assign wr_dir  = dec.wr && (dec.sel == SEL_DIR);
    assign wr_dat  = dec.wr && (dec.sel == SEL_DATA);
    assign wr_ien  = dec.wr && (dec.sel == SEL_IEN);
    assign wr_chg  = dec.wr && (dec.sel == SEL_CHG);
    assign wr_msk  = dec.wr && (dec.sel == SEL_WMASK);
    assign ack_vec = wr_chg ? wr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            dat_q   <= '0;
            ien_q   <= '0;
            wmask_q <= '1;
        end else begin
            if (wr_dir) dir_q   <= wr_bits;
            if (wr_dat) dat_q   <= (dat_q & ~wmask_q) | (wr_bits & wmask_q);
            if (wr_ien) ien_q   <= wr_bits;
            if (wr_msk) wmask_q <= wr_bits;
        end
    end

    gpio_in_sync #(.NPIN(NPIN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .level  (sync_lvl),
        .step   (step_vec)
    );

    gpio_chg_latch #(.NPIN(NPIN)) u_chg (
        .clk     (clk),
        .rst     (rst),
        .step    (step_vec),
        .ack     (ack_vec),
        .enable  (ien_q),
        .pending (chg_vec),
        .irq     (irq)
    );

    // Read mux: unimplemented upper bits are zero-filled.
    always_comb begin
        logic [BUS_W-1:0] wide;
        wide = '0;
        unique case (dec.sel)
            SEL_DIR:   wide[NPIN-1:0] = dir_q;
            SEL_DATA:  wide[NPIN-1:0] = sync_lvl;
            SEL_IEN:   wide[NPIN-1:0] = ien_q;
            SEL_CHG:   wide[NPIN-1:0] = chg_vec;
            SEL_WMASK: wide[NPIN-1:0] = wmask_q;
            SEL_TYPE:  wide           = TYPE_BOTH_EDGES;
            default:   wide           = '0;
        endcase
        bus_rdata = dec.hit ? wide : '0;
    end

    assign pad_out = dat_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/edge_gpio_chk.sv
module edge_gpio_chk #(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_dir,
    input logic            wr_dat,
    input logic            wr_chg,
    input logic [NPIN-1:0] wbits,
    input logic [NPIN-1:0] step_vec,
    input logic [NPIN-1:0] chg_vec,
    input logic [NPIN-1:0] ien_q,
    input logic [NPIN-1:0] wmask_q,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic            irq
);
    // R5: every step is captured on the next edge
    a_r5_step_latched: assert property (@(posedge clk) disable iff (rst)
        (step_vec != '0) |=> ((chg_vec & $past(step_vec)) == $past(step_vec)));

    // R5: no change bit appears without a step
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (($past(step_vec) == '0) && !$past(rst)) |-> ((chg_vec & ~$past(chg_vec)) == '0));

    // R6: clear without a coincident step empties the written bits
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_chg && ((wbits & step_vec) == '0)) |=> ((chg_vec & $past(wbits)) == '0));

    // R7: coincident step and clear leaves the bit set
    a_r7_step_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_chg && ((wbits & step_vec) != '0)) |=> ((chg_vec & $past(wbits & step_vec)) != '0));

    // R8: no interrupt while every enable is clear
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

    // R2: output enables follow a direction write
    a_r2_dir_follow: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> (pad_oe == $past(wbits)));

    // R3: masked data write
    a_r3_masked_write: assert property (@(posedge clk) disable iff (rst)
        wr_dat |=> (pad_out == (($past(pad_out) & ~$past(wmask_q)) | ($past(wbits) & $past(wmask_q)))));
endmodule

bind edge_gpio edge_gpio_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_dir   (wr_dir),
    .wr_dat   (wr_dat),
    .wr_chg   (wr_chg),
    .wbits    (wr_bits),
    .step_vec (step_vec),
    .chg_vec  (chg_vec),
    .ien_q    (ien_q),
    .wmask_q  (wmask_q),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq)
);

// File: tb/sim_edge_gpio.sv
`timescale 1ns/1ps
module sim_edge_gpio;
    localparam int NPIN = 24;
    localparam int ADDR_W = 5;
    localparam logic [31:0] PMASK = 32'h00FF_FFFF;
    localparam logic [4:0] A_DIR = 5'h00, A_DATA = 5'h04, A_IEN = 5'h08,
                           A_CHG = 5'h0C, A_MSK = 5'h10, A_TYPE = 5'h14;

    // {pad pattern, enable}
    localparam int NVEC = 6;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0000_0001, 32'h0000_0001},
        {32'h0000_0000, 32'h0000_0000},
        {32'h00A5_A5A5, 32'hFFFF_FFFF},
        {32'h005A_5A5A, 32'h0000_0100},
        {32'h005A_5A5A, 32'h00FF_FFFF},
        {32'h00FF_0000, 32'h0000_00FF}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPIN-1:0]   pad_in = '0;
    logic [NPIN-1:0]   pad_out, pad_oe;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_gpio #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] prev;
        logic [31:0] pat, en, exp_chg;

        repeat (4) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R10 type, R11 mask reset
        rd(A_DIR, r);  check("R1 dir", r, 32'h0);
        rd(A_DATA, r); check("R1 data", r, 32'h0);
        rd(A_IEN, r);  check("R1 ien", r, 32'h0);
        rd(A_CHG, r);  check("R1 chg", r, 32'h0);
        rd(A_MSK, r);  check("R1 R11 wmask reset", r, PMASK);
        rd(A_TYPE, r); check("R10 type", r, 32'h3);
        check("R1 pad_oe", {8'h0, pad_oe}, 32'h0);
        check("R1 pad_out", {8'h0, pad_out}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 direction
        wr(A_DIR, 32'h00F0_F00F);
        check("R2 pad_oe", {8'h0, pad_oe}, 32'h00F0_F00F);
        rd(A_DIR, r); check("R2 dir readback", r, 32'h00F0_F00F);

        // R3 masked data write, R11 mask write
        wr(A_DATA, 32'h00FF_FFFF);
        check("R3 full write", {8'h0, pad_out}, 32'h00FF_FFFF);
        wr(A_MSK, 32'h0000_00FF);
        rd(A_MSK, r); check("R11 wmask readback", r, 32'h0000_00FF);
        wr(A_DATA, 32'h0000_0000);
        check("R3 masked write", {8'h0, pad_out}, 32'h00FF_FF00);
        wr(A_MSK, 32'hFFFF_FFFF);

        // R9 upper bits
        wr(A_DIR, 32'hFFFF_FFFF);
        rd(A_DIR, r); check("R9 dir upper zero", r, PMASK);
        wr(A_IEN, 32'hFF00_0000);
        rd(A_IEN, r); check("R9 ien upper ignored", r, 32'h0);

        // R10 type write ignored
        wr(A_TYPE, 32'h0);
        rd(A_TYPE, r); check("R10 type after write", r, 32'h3);

        // R12 unmapped / unaligned
        rd(5'h18, r); check("R12 unmapped read", r, 32'h0);
        rd(5'h01, r); check("R12 unaligned read", r, 32'h0);
        wr(5'h05, 32'h0);
        check("R12 unaligned write ignored", {8'h0, pad_out}, 32'h00FF_FF00);

        // Table walk: R4 data read, R5 change latch, R8 irq
        prev = 32'h0;
        for (int i = 0; i < NVEC; i++) begin
            pat = VEC[i][63:32];
            en  = VEC[i][31:0];
            wr(A_CHG, 32'hFFFF_FFFF);
            wr(A_IEN, en);
            @(negedge clk);
            pad_in = pat[NPIN-1:0];
            settle();
            exp_chg = (pat ^ prev) & PMASK;
            rd(A_DATA, r); check($sformatf("R4 data vec%0d", i), r, pat & PMASK);
            rd(A_CHG, r);  check($sformatf("R5 chg vec%0d", i), r, exp_chg);
            check($sformatf("R8 irq vec%0d", i), {31'b0, irq},
                  {31'b0, |(exp_chg & en)});
            prev = pat;
        end

        // R6 write-one-to-clear
        wr(A_CHG, 32'hFFFF_FFFF);
        wr(A_IEN, 32'h0);
        @(negedge clk);
        pad_in = pad_in ^ 24'h3;
        settle();
        rd(A_CHG, r); check("R6 two pending", r, 32'h3);
        wr(A_CHG, 32'h1);
        rd(A_CHG, r); check("R6 clear one keep other", r, 32'h2);

        // R8 masking keeps the latched change
        check("R8 masked irq low", {31'b0, irq}, 32'h0);
        rd(A_CHG, r); check("R8 masked change kept", r, 32'h2);
        wr(A_IEN, 32'h2);
        check("R8 unmask irq high", {31'b0, irq}, 32'h1);
        wr(A_CHG, 32'h2);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h0);

        // R7 step and clear in the same cycle
        @(negedge clk);
        pad_in = pad_in ^ 24'h1;
        settle();
        rd(A_CHG, r); check("R7 setup pending", r, 32'h1);
        @(negedge clk);
        pad_in = pad_in ^ 24'h1;          // sampled at next edge
        @(negedge clk);                   // meta stage loaded
        @(negedge clk);                   // sync stage loaded, step high now
        bus_addr = A_CHG; bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_CHG, r); check("R7 step wins over clear", r, 32'h1);
        wr(A_CHG, 32'h1);
        rd(A_CHG, r); check("R7 later clear works", r, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule